// File: doc/BRIEF.md
# Multi-channel down-counting timer

This block holds a set of independent down-counters that share one interrupt line. Each channel counts down once per tick. A tick comes on every clock, or on every sixteenth clock when the channel's divider is selected. A channel can run periodically, where it reloads and keeps going, or as a one-shot, where it stops after it reaches zero. Software that needs a rising timestamp negates the value it reads back. A counter can be narrowed to the low half of its width.

Software reaches every register through a plain single-cycle port. A write is taken on the clock edge on which `bus_wen` is high. Read data is combinational from `bus_addr`, so a read returns the live count in the same cycle. A reaching-zero event sets that channel's raw pending bit whatever the mask holds. The interrupt output is the OR over all channels of pending AND mask.

Top module: `dctimer_unit`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map, using word addresses. Channel n owns addresses 4n+0 (control), 4n+1 (load), 4n+2 (live value, read-only) and 4n+3 (reload only). The shared registers follow at 4N+0 (mask), 4N+1 (raw pending, read-only), 4N+2 (masked pending, read-only) and 4N+3 (clear, write-only). Control bits are: bit0 enable, bit1 full width (1 = 32-bit, 0 = low 16 bits), bit2 one-shot, bit3 divide-by-16. Mask, pending and clear use bit n for channel n.
- R3: With divide-by-1 an enabled channel decrements on every clock edge after the edge that enabled it.
- R4: With divide-by-16 the first decrement falls on the 16th edge after enable and every 16 edges after that. Turning enable from 0 to 1 restarts the divider.
- R5: A write to the load register replaces the count on that same edge, with no tick on that edge. It also sets the reload value, and the load and reload addresses both read back that value.
- R6: A write to the reload-only address changes only the value used at the next wrap. The running count keeps ticking undisturbed.
- R7: In periodic mode a tick from a count of 1 sets the channel's raw bit and loads the reload value. A reload value of N gives an interrupt every N ticks.
- R8: A count of 0 decrements to all ones within the active width. A reload of zero therefore gives a period of 2^32 ticks at full width, or 2^16 ticks at 16-bit width.
- R9: In one-shot mode, reaching zero sets the raw bit, and the count then holds 0 with no further events until the load register is written.
- R10: Clearing enable freezes the count. A tick still due on the edge that clears it is applied.
- R11: In 16-bit mode the count, the loaded value and the value read back are limited to the low 16 bits, and the count wraps within them.
- R12: The raw bit is set whether or not it is masked. `irq` is high exactly when some raw bit and its mask bit are both 1, and the masked pending register reads raw AND mask.
- R13: Writing 1 to bit n of the clear register clears raw bit n. Zero bits leave their pending bits alone. A reaching-zero event on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | AW (5) | Word address for reads and writes |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Combinational read data for `bus_addr` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench sweeps every channel over short periods and checks the count on every tick and the exact edge on which pending rises. A design with an off-by-one reload or with cross-channel address decoding would show a wrong period or a wrong pending bit. Mid-count load and reload writes separate the two registers: reload that takes effect at once, or load that waits for the wrap, gives a wrong count. The divider is re-enabled after a partial prescale, so a divider that is not restarted ticks early. Full-range wraps are run through in 16-bit mode, and a clear is timed onto the same edge as a zero event, which a design that lets the clear win would lose. One-shot channels are watched for ten cycles after expiry, where a design that keeps counting or fires again would show up.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
  localparam int REGS_PER_CH   = 4;
  localparam int PRESCALE_LOG2 = 4;

  typedef enum logic [1:0] {
    SLOT_CTRL   = 2'd0,
    SLOT_LOAD   = 2'd1,
    SLOT_VALUE  = 2'd2,
    SLOT_RELOAD = 2'd3
  } slot_e;

  // shared register slots after the channel region
  typedef enum logic [1:0] {
    SH_MASK = 2'd0,
    SH_RAW  = 2'd1,
    SH_MIS  = 2'd2,
    SH_CLR  = 2'd3
  } shared_e;

  // bit0 en, bit1 wide, bit2 oneshot, bit3 div16
  typedef struct packed {
    logic div16;
    logic oneshot;
    logic wide;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dct_prescaler.sv
`timescale 1ns/1ps
module dct_prescaler #(
  parameter int LOG2_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic use_div,
  output logic tick
);
  logic [LOG2_DIV-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= phase_q + 1'b1;
  end

  assign tick = run && (use_div ? (&phase_q) : 1'b1);
endmodule

// File: rtl/dct_channel.sv
`timescale 1ns/1ps
module dct_channel
  import dct_pkg::*;
#(
  parameter int CW       = 32,
  parameter int PS_LOG2  = PRESCALE_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          load_we,
  input  logic          reload_we,
  input  ctrl_t         ctrl_wdata,
  input  logic [CW-1:0] data_wdata,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] reload_o,
  output logic          zero_hit,
  output logic          halted
);
  localparam int HALF = CW / 2;
  localparam logic [CW-1:0] NARROW_MASK = {{(CW-HALF){1'b0}}, {HALF{1'b1}}};

  ctrl_t         ctrl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload_q;
  logic          done_q;

  logic [CW-1:0] width_mask;
  logic [CW-1:0] cur;
  logic [CW-1:0] dec;
  logic          at_one;
  logic          tick;
  logic          en_rise;

  assign width_mask = ctrl_q.wide ? {CW{1'b1}} : NARROW_MASK;
  assign cur        = cnt_q & width_mask;
  assign dec        = (cur - 1'b1) & width_mask;
  assign at_one     = (cur == CW'(1));
  assign en_rise    = ctrl_we && ctrl_wdata.en && !ctrl_q.en;

  dct_prescaler #(.LOG2_DIV(PS_LOG2)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.en && !done_q),
    .restart (en_rise),
    .use_div (ctrl_q.div16),
    .tick    (tick)
  );

  assign zero_hit = tick && at_one && !load_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (load_we || reload_we) begin
      reload_q <= data_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_we) begin
      cnt_q  <= data_wdata & width_mask;
      done_q <= 1'b0;
    end else if (tick) begin
      if (at_one) begin
        if (ctrl_q.oneshot) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q  <= reload_q & width_mask;
        end
      end else begin
        cnt_q <= dec;
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign count_o  = cur;
  assign reload_o = reload_q;
  assign halted   = done_q;
endmodule

// File: rtl/dctimer_unit.sv
`timescale 1ns/1ps
module dctimer_unit
  import dct_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  localparam int AW = $clog2(REGS_PER_CH * (NCH + 1))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wen,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi;
  slot_e         slot;
  shared_e       sh_slot;
  logic          shared_sel;

  ctrl_t                  ctrl_v [NCH];
  logic [NCH-1:0][CW-1:0] cnt_v;
  logic [NCH-1:0][CW-1:0] rel_v;
  logic [NCH-1:0]         zhit;
  logic [NCH-1:0]         done_v;
  logic [NCH-1:0]         en_v;
  logic [NCH-1:0]         wide_v;
  logic [NCH-1:0]         raw_q;
  logic [NCH-1:0]         mask_q;
  logic [NCH-1:0]         clr_bits;
  ctrl_t                  wctrl;

  assign hi         = bus_addr[AW-1:2];
  assign slot       = slot_e'(bus_addr[1:0]);
  assign sh_slot    = shared_e'(bus_addr[1:0]);
  assign shared_sel = (hi == HW'(NCH));
  assign wctrl      = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = bus_wen && (hi == HW'(i));

    dct_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (sel && slot == SLOT_CTRL),
      .load_we    (sel && slot == SLOT_LOAD),
      .reload_we  (sel && slot == SLOT_RELOAD),
      .ctrl_wdata (wctrl),
      .data_wdata (bus_wdata),
      .ctrl_o     (ctrl_v[i]),
      .count_o    (cnt_v[i]),
      .reload_o   (rel_v[i]),
      .zero_hit   (zhit[i]),
      .halted     (done_v[i])
    );

    assign en_v[i]   = ctrl_v[i].en;
    assign wide_v[i] = ctrl_v[i].wide;
  end

  assign clr_bits = (bus_wen && shared_sel && sh_slot == SH_CLR) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (bus_wen && shared_sel && sh_slot == SH_MASK) mask_q <= bus_wdata[NCH-1:0];
      raw_q <= (raw_q & ~clr_bits) | zhit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hi == HW'(i)) begin
        case (slot)
          SLOT_CTRL:   bus_rdata = CW'(ctrl_v[i]);
          SLOT_LOAD:   bus_rdata = rel_v[i];
          SLOT_VALUE:  bus_rdata = cnt_v[i];
          SLOT_RELOAD: bus_rdata = rel_v[i];
          default:     bus_rdata = '0;
        endcase
      end
    end
    if (shared_sel) begin
      case (sh_slot)
        SH_MASK: bus_rdata = CW'(mask_q);
        SH_RAW:  bus_rdata = CW'(raw_q);
        SH_MIS:  bus_rdata = CW'(raw_q & mask_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/dct_checker.sv
`timescale 1ns/1ps
module dct_checker #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wen,
  input logic [AW-1:0]         bus_addr,
  input logic [CW-1:0]         bus_wdata,
  input logic [CW-1:0]         bus_rdata,
  input logic                  irq,
  input logic [NCH-1:0]        raw_q,
  input logic [NCH-1:0]        mask_q,
  input logic [NCH-1:0]        zhit,
  input logic [NCH-1:0]        done_v,
  input logic [NCH-1:0]        en_v,
  input logic [NCH-1:0]        wide_v,
  input logic [NCH-1:0][CW-1:0] cnt_v
);
  localparam logic [AW-1:0] MASK_A = AW'(4 * NCH);
  localparam logic [AW-1:0] CLR_A  = AW'(4 * NCH + 3);

  assert_irq_needs_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  assert_mask_zero_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == MASK_A && bus_wdata[NCH-1:0] == '0) |=> !irq);

  assert_clear_takes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == CLR_A) |=> ((raw_q & $past(bus_wdata[NCH-1:0] & ~zhit)) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic touch;
    assign touch = bus_wen && (bus_addr[AW-1:2] == (AW-2)'(i));

    assert_raw_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      zhit[i] |=> raw_q[i]);

    assert_oneshot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_v[i] && !touch) |=> (done_v[i] && cnt_v[i] == '0));

    assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[i] && !touch) |=> $stable(cnt_v[i]));

    assert_narrow_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(4 * i + 2) && !wide_v[i]) |-> (bus_rdata[CW-1:CW/2] == '0));
  end
endmodule

bind dctimer_unit dct_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_dct_checker (.*);

// File: tb/dctimer_unit_bench.sv
`timescale 1ns/1ps
module dctimer_unit_bench;
  localparam int NCH = 4;
  localparam int AW  = 5;
  localparam logic [31:0] EN = 32'h1, WIDE = 32'h2, OS = 32'h4, D16 = 32'h8;
  localparam logic [4:0] MASK_A = 5'd16, RAW_A = 5'd17, MIS_A = 5'd18, CLR_A = 5'd19;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wen;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dctimer_unit u_dctimer_unit (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [4:0] ra(input int ch, input int slot);
    return 5'(4 * ch + slot);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // caller sits at a negedge; returns at the next negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(4);
    rst_n = 1'b1;
    step(1);

    // R1: everything zero after reset
    for (int a = 0; a < 20; a++) chk_rd("R1 reset reg", 5'(a), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 R3 R7: period sweep over every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(ra(ch, 1), 32'(n));
        chk_rd("R5 load while idle", ra(ch, 2), 32'(n));
        wr(CLR_A, 32'hF);
        wr(ra(ch, 0), EN | WIDE);
        chk_rd("R2 ctrl readback", ra(ch, 0), EN | WIDE);
        for (int k = 1; k <= n; k++) begin
          step(1);
          chk_rd("R3 count", ra(ch, 2), (k < n) ? 32'(n - k) : 32'(n));
          chk_rd("R7 raw", RAW_A, (k < n) ? 32'h0 : (32'h1 << ch));
        end
        wr(ra(ch, 0), WIDE);
      end
    end
    wr(CLR_A, 32'hF);

    // R12: masking on channel 2
    wr(ra(2, 1), 32'd1);
    wr(ra(2, 0), EN | WIDE);
    step(1);
    wr(ra(2, 0), WIDE);
    chk_rd("R12 raw set unmasked", RAW_A, 32'h4);
    check("R12 irq masked off", {31'b0, irq}, 32'h0);
    wr(MASK_A, 32'h4);
    check("R12 irq on", {31'b0, irq}, 32'h1);
    chk_rd("R12 masked status", MIS_A, 32'h4);
    wr(MASK_A, 32'hB);
    check("R12 irq other mask", {31'b0, irq}, 32'h0);
    chk_rd("R12 masked status zero", MIS_A, 32'h0);

    // R13: write-one-to-clear
    wr(CLR_A, 32'hB);
    chk_rd("R13 zeros ignored", RAW_A, 32'h4);
    wr(CLR_A, 32'h4);
    chk_rd("R13 cleared", RAW_A, 32'h0);
    wr(MASK_A, 32'h0);
    wr(ra(3, 1), 32'd2);
    wr(ra(3, 0), EN | WIDE);
    step(1);
    chk_rd("R13 pre count", ra(3, 2), 32'd1);
    wr(CLR_A, 32'h8);
    chk_rd("R13 set beats clear", RAW_A, 32'h8);
    wr(ra(3, 0), WIDE);
    wr(CLR_A, 32'hF);

    // R4: divide by 16 and restart
    wr(ra(0, 1), 32'd3);
    wr(ra(0, 0), EN | WIDE | D16);
    step(15);
    chk_rd("R4 before 16th edge", ra(0, 2), 32'd3);
    step(1);
    chk_rd("R4 16th edge", ra(0, 2), 32'd2);
    step(16);
    chk_rd("R4 32nd edge", ra(0, 2), 32'd1);
    wr(ra(0, 0), WIDE | D16);
    wr(ra(0, 1), 32'd5);
    wr(ra(0, 0), EN | WIDE | D16);
    step(15);
    chk_rd("R4 restart hold", ra(0, 2), 32'd5);
    step(1);
    chk_rd("R4 restart tick", ra(0, 2), 32'd4);
    wr(ra(0, 0), WIDE);

    // R5 R6: load immediate, reload deferred
    wr(ra(1, 1), 32'd100);
    wr(ra(1, 0), EN | WIDE);
    step(10);
    chk_rd("R3 running", ra(1, 2), 32'd90);
    wr(ra(1, 1), 32'd40);
    chk_rd("R5 load immediate", ra(1, 2), 32'd40);
    step(1);
    chk_rd("R5 after load", ra(1, 2), 32'd39);
    chk_rd("R5 load readback", ra(1, 1), 32'd40);
    chk_rd("R5 reload readback", ra(1, 3), 32'd40);
    wr(ra(1, 3), 32'd7);
    chk_rd("R6 count undisturbed", ra(1, 2), 32'd38);
    wr(CLR_A, 32'hF);
    step(36);
    chk_rd("R6 at one", ra(1, 2), 32'd1);
    chk_rd("R6 no early raw", RAW_A, 32'h0);
    step(1);
    chk_rd("R6 wrap uses reload", ra(1, 2), 32'd7);
    chk_rd("R6 raw at wrap", RAW_A, 32'h2);
    wr(ra(1, 0), WIDE);

    // R10: disable freezes
    wr(ra(0, 1), 32'd50);
    wr(ra(0, 0), EN | WIDE);
    step(5);
    chk_rd("R10 running", ra(0, 2), 32'd45);
    wr(ra(0, 0), WIDE);
    chk_rd("R10 last tick", ra(0, 2), 32'd44);
    step(10);
    chk_rd("R10 frozen", ra(0, 2), 32'd44);

    // R8: zero load at full width
    wr(ra(2, 1), 32'd0);
    wr(ra(2, 0), EN | WIDE);
    step(1);
    chk_rd("R8 wide wrap", ra(2, 2), 32'hFFFF_FFFF);
    step(1);
    chk_rd("R8 wide next", ra(2, 2), 32'hFFFF_FFFE);
    wr(ra(2, 0), WIDE);

    // R11 R8: 16-bit mode and full 2^16 period
    wr(ra(3, 0), 32'h0);
    wr(ra(3, 1), 32'h0001_2345);
    chk_rd("R11 load truncated", ra(3, 2), 32'h0000_2345);
    chk_rd("R11 reload full", ra(3, 1), 32'h0001_2345);
    wr(ra(3, 1), 32'h0);
    wr(CLR_A, 32'hF);
    wr(ra(3, 0), EN);
    step(1);
    chk_rd("R11 narrow wrap", ra(3, 2), 32'h0000_FFFF);
    step(65534);
    chk_rd("R8 narrow at one", ra(3, 2), 32'd1);
    chk_rd("R8 narrow no raw", RAW_A, 32'h0);
    step(1);
    chk_rd("R8 narrow period", RAW_A, 32'h8);
    chk_rd("R8 narrow reload zero", ra(3, 2), 32'h0);
    wr(ra(3, 0), 32'h0);

    // R9: one-shot
    wr(ra(0, 1), 32'd3);
    wr(CLR_A, 32'hF);
    wr(ra(0, 0), EN | WIDE | OS);
    step(2);
    chk_rd("R9 counting", ra(0, 2), 32'd1);
    step(1);
    chk_rd("R9 expired", ra(0, 2), 32'd0);
    chk_rd("R9 raw", RAW_A, 32'h1);
    step(10);
    chk_rd("R9 held", ra(0, 2), 32'd0);
    wr(CLR_A, 32'h1);
    step(5);
    chk_rd("R9 no refire", RAW_A, 32'h0);
    chk_rd("R9 still zero", ra(0, 2), 32'd0);
    wr(ra(0, 1), 32'd2);
    chk_rd("R9 rearm", ra(0, 2), 32'd2);
    step(2);
    chk_rd("R9 second expiry", RAW_A, 32'h1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule